// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block moves bytes between one peripheral and memory so the processor does not copy each one. Software programs a start address, a byte count and a control word through a small register port. The peripheral then raises `dreq` to ask for service. The controller answers on the memory side with the bus-request pair `hold`/`hlda`, or, in hidden mode, with the processor's bus-floated flag `bus_float`. Each byte moved is marked by `dack`.

The data path is fly-by and takes no buffering. In each transfer cycle the byte passes straight between `io_rdata` and `mem_wdata`, or between `mem_rdata` and `io_wdata`, while the controller drives `mem_addr` and one strobe. The peripheral holds the data back by dropping `dreq`, which acts as its valid. The processor holds it back by withholding or withdrawing `hlda`, which acts as the bus-side ready. In hidden mode `bus_float` plays that role. A byte moves only in a cycle where both sides allow it. When the last byte is done, `tc` pulses.

There are three bus-sharing modes. Burst keeps the bus until the count runs out. Cycle-steal gives the bus back after every byte. Hidden never asks for the bus and uses only the cycles the processor leaves idle.

Top module: `dma_single_chan`

## Requirements
- R1: After reset `hold`, `dack`, `mem_rd`, `mem_wr` and `tc` are low, and the count register reads 0 with the busy bit clear.
- R2: Register index 0 holds the start address, 1 the byte count and 2 the control word. The control word has bit 0 for direction (0 = peripheral to memory, 1 = memory to peripheral), bit 1 for address stepping (0 = up, 1 = down) and bits 3:2 for mode (00 burst, 01 cycle-steal, 10 hidden, 11 acts as burst). Reading index 2 returns those bits plus a busy flag in bit 4, which is set while the count is nonzero. Writes made while busy are ignored.
- R3: In burst or cycle-steal mode, `dreq` high with a nonzero count raises `hold` one clock later. No `dack` and no memory strobe appear until `hlda` is high.
- R4: In a transfer cycle `dack` is high together with exactly one strobe, and `mem_addr` carries the current address. With direction 0 the strobe is `mem_wr` and `mem_wdata` equals `io_rdata`. With direction 1 the strobe is `mem_rd` and `io_wdata` equals `mem_rdata`.
- R5: After each byte the address moves by one in the configured direction and the count drops by one.
- R6: In burst mode, bytes follow back to back in every cycle with `hlda` and `dreq` high. `hold` stays high until the last byte and is low on the clock after it.
- R7: In cycle-steal mode one byte is moved per grant, and `hold` is low on the clock after each byte. `hold` rises again only while the count is nonzero and `dreq` is high.
- R8: In hidden mode `hold` is never raised. A byte moves in exactly those cycles where `bus_float` and `dreq` are high and the count is nonzero.
- R9: `tc` is high for exactly one clock, the clock after the last byte, and the count then reads 0.
- R10: If `hlda` falls during a burst, no byte moves while it is low. `hold` stays high, the remaining count is kept, and transfers resume once `hlda` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | 2 | Register write index |
| cfg_wdata | input | REG_W | Register write data |
| cfg_raddr | input | 2 | Register read index |
| cfg_rdata | output | REG_W | Register read data (combinational) |
| dreq | input | 1 | Peripheral service request (valid) |
| dack | output | 1 | Byte being moved this cycle |
| io_rdata | input | DATA_W | Byte from peripheral |
| io_wdata | output | DATA_W | Byte to peripheral |
| hold | output | 1 | Bus request to processor |
| hlda | input | 1 | Bus grant from processor (ready) |
| bus_float | input | 1 | Processor has floated its buses this cycle |
| mem_addr | output | ADDR_W | Memory address, driven in transfer cycles |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Byte to memory |
| mem_rdata | input | DATA_W | Byte from memory |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bound checker examines every cycle for the following:
- no `dack` without a granted bus outside hidden mode;
- strobes only alongside `dack`;
- address and count stepping after each byte;
- `hold` falling after every cycle-steal byte and staying up inside a burst;
- hidden mode never requesting the bus and moving bytes only while `bus_float` is high;
- `tc` being a single pulse that follows the final byte.

Some behaviours show only in the directed scenarios. These are the register layout and the writes ignored while busy, the data routing in each direction, the gap with `hold` low while `dreq` is idle in cycle-steal, the retained count across a withdrawn grant, and the exact cycles of each transfer against an irregular `bus_float` pattern.

// File: rtl/dma_sc_pkg.sv
package dma_sc_pkg;

  typedef enum logic [1:0] {
    MODE_BURST  = 2'b00,
    MODE_STEAL  = 2'b01,
    MODE_HIDDEN = 2'b10,
    MODE_ALT    = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } bus_st_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       down;
    logic       to_io;
  } chan_cfg_t;

  localparam logic [1:0] IDX_ADDR  = 2'd0;
  localparam logic [1:0] IDX_COUNT = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;
  localparam int         CFG_BITS  = $bits(chan_cfg_t);

endpackage

// File: rtl/dma_sc_regs.sv
module dma_sc_regs
  import dma_sc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [1:0]        cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output chan_cfg_t         cfg
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  chan_cfg_t         cfg_q;
  logic              busy;
  logic              wr_ok;

  assign busy  = (cnt_q != '0);
  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      cfg_q  <= '0;
    end else if (step) begin
      addr_q <= cfg_q.down ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
      cnt_q  <= cnt_q - CNT_W'(1);
    end else if (wr_ok) begin
      case (cfg_waddr)
        IDX_ADDR:  addr_q <= cfg_wdata[ADDR_W-1:0];
        IDX_COUNT: cnt_q  <= cfg_wdata[CNT_W-1:0];
        IDX_CTRL:  cfg_q  <= chan_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (cfg_raddr)
      IDX_ADDR:  cfg_rdata = REG_W'(addr_q);
      IDX_COUNT: cfg_rdata = REG_W'(cnt_q);
      IDX_CTRL:  cfg_rdata = REG_W'({busy, cfg_q});
      default:   cfg_rdata = '0;
    endcase
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign cfg      = cfg_q;

endmodule

// File: rtl/dma_sc_seq.sv
module dma_sc_seq
  import dma_sc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_e       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dreq,
  input  logic             hlda,
  input  logic             bus_float,
  output logic             hold,
  output logic             xfer,
  output logic             tc
);

  bus_st_e st_q, st_d;
  logic    pending, last_byte, hidden;
  logic    tc_q;

  assign pending   = (cnt != '0);
  assign last_byte = (cnt == CNT_W'(1));
  assign hidden    = (mode == MODE_HIDDEN);

  always_comb begin
    xfer = 1'b0;
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (hidden) xfer = pending && dreq && bus_float;
        else if (pending && dreq) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (hlda) st_d = ST_OWN;
      end
      ST_OWN: begin
        xfer = hlda && dreq;
        if (!hlda)                    st_d = ST_REQ;
        else if (!dreq)               st_d = ST_IDLE;
        else if (last_byte)           st_d = ST_IDLE;
        else if (mode == MODE_STEAL)  st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      tc_q <= 1'b0;
    end else begin
      st_q <= st_d;
      tc_q <= xfer && last_byte;
    end
  end

  assign hold = (st_q != ST_IDLE);
  assign tc   = tc_q;

endmodule

// File: rtl/dma_sc_path.sv
module dma_sc_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              xfer,
  input  logic              to_io,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dack,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] io_wdata
);

  assign dack      = xfer;
  assign mem_rd    = xfer && to_io;
  assign mem_wr    = xfer && !to_io;
  assign mem_addr  = xfer ? cur_addr : '0;
  assign mem_wdata = mem_wr ? io_rdata : '0;
  assign io_wdata  = mem_rd ? mem_rdata : '0;

endmodule

// File: rtl/dma_single_chan.sv
module dma_single_chan
  import dma_sc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [1:0]        cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              dreq,
  output logic              dack,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] io_wdata,
  output logic              hold,
  input  logic              hlda,
  input  logic              bus_float,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tc
);

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  chan_cfg_t         chan_cfg;
  xfer_mode_e        cur_mode;
  logic              xfer;

  assign cur_mode = chan_cfg.mode;

  dma_sc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_waddr (cfg_waddr),
    .cfg_wdata (cfg_wdata),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .step      (xfer),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .cfg       (chan_cfg)
  );

  dma_sc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cur_mode),
    .cnt       (cur_cnt),
    .dreq      (dreq),
    .hlda      (hlda),
    .bus_float (bus_float),
    .hold      (hold),
    .xfer      (xfer),
    .tc        (tc)
  );

  dma_sc_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .xfer      (xfer),
    .to_io     (chan_cfg.to_io),
    .cur_addr  (cur_addr),
    .io_rdata  (io_rdata),
    .mem_rdata (mem_rdata),
    .dack      (dack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .io_wdata  (io_wdata)
  );

endmodule

// File: rtl/dma_single_chan_chk.sv
module dma_single_chan_chk
  import dma_sc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dack,
  input logic              hold,
  input logic              hlda,
  input logic              bus_float,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              tc,
  input chan_cfg_t         cfg,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  cnt
);

  logic is_hidden, is_steal, is_burst;
  assign is_hidden = (cfg.mode == MODE_HIDDEN);
  assign is_steal  = (cfg.mode == MODE_STEAL);
  assign is_burst  = !is_hidden && !is_steal;

  // R3
  grant_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !is_hidden) |-> (hold && hlda));

  // R4
  strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> dack);

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (mem_rd != mem_wr));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dack) |-> (cnt == $past(cnt) - CNT_W'(1)));

  // R5
  addr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dack) && !$past(cfg.down)) |-> (addr == $past(addr) + ADDR_W'(1)));

  // R5
  addr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dack) && $past(cfg.down)) |-> (addr == $past(addr) - ADDR_W'(1)));

  // R6
  burst_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && is_burst && cnt != CNT_W'(1)) |=> hold);

  // R7
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && is_steal) |=> !hold);

  // R8
  hidden_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_hidden |-> !hold);

  // R8
  hidden_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && is_hidden) |-> bus_float);

  // R9
  tc_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ($past(dack) && cnt == '0));

  // R9
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

endmodule

bind dma_single_chan dma_single_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack      (dack),
  .hold      (hold),
  .hlda      (hlda),
  .bus_float (bus_float),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .tc        (tc),
  .cfg       (chan_cfg),
  .addr      (cur_addr),
  .cnt       (cur_cnt)
);

// File: tb/sim_dma_single_chan.sv
`timescale 1ns/1ps
module sim_dma_single_chan;

  localparam int AW = 16, CW = 16, DW = 8, RW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_waddr = '0, cfg_raddr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          dreq = 1'b0, hlda = 1'b0, bus_float = 1'b0;
  logic          dack, hold, mem_rd, mem_wr, tc;
  logic [DW-1:0] io_rdata = '0, mem_rdata = '0, io_wdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_single_chan #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .dreq(dreq), .dack(dack), .io_rdata(io_rdata), .io_wdata(io_wdata),
    .hold(hold), .hlda(hlda), .bus_float(bus_float), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tc(tc)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [RW-1:0] val);
    cfg_we = 1'b1; cfg_waddr = idx; cfg_wdata = val;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [RW-1:0] val);
    cfg_raddr = idx;
    #1;
    val = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [RW-1:0] v;
    #1;
    chk("R1", "hold", hold, 0);
    chk("R1", "dack", dack, 0);
    chk("R1", "strobes", {mem_rd, mem_wr}, 0);
    chk("R1", "tc", tc, 0);
    rd(2'd1, v); chk("R1", "count", v, 0);
    rd(2'd2, v); chk("R1", "busy", v[4], 0);
  endtask

  task automatic t_regs();
    logic [RW-1:0] v;
    wr(2'd2, 16'h0008);
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'd2);
    rd(2'd0, v); chk("R2", "addr readback", v, 16'h1234);
    rd(2'd1, v); chk("R2", "count readback", v, 2);
    rd(2'd2, v); chk("R2", "ctrl+busy", v, 16'h0018);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd7);
    rd(2'd0, v); chk("R2", "addr write ignored", v, 16'h1234);
    rd(2'd1, v); chk("R2", "count write ignored", v, 2);
    dreq = 1'b1; bus_float = 1'b1;
    step(); step();
    dreq = 1'b0; bus_float = 1'b0;
    rd(2'd2, v); chk("R2", "busy clears", v, 16'h0008);
    step();
  endtask

  task automatic t_burst();
    logic [RW-1:0] v;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'd4);
    dreq = 1'b1;
    #1; chk("R3", "no hold before edge", hold, 0);
    step(); #1;
    chk("R3", "hold raised", hold, 1);
    chk("R3", "no dack without grant", dack, 0);
    step(); #1;
    chk("R3", "still waiting", {dack, mem_wr, mem_rd}, 0);
    hlda = 1'b1; #1;
    chk("R3", "grant seen, not yet owner", dack, 0);
    step();
    for (int i = 0; i < 4; i++) begin
      io_rdata = 8'hA0 + 8'(i); #1;
      chk("R6", "burst dack", dack, 1);
      chk("R4", "write strobe", {mem_wr, mem_rd}, 2'b10);
      chk("R5", "addr up", mem_addr, 16'h0100 + i);
      chk("R4", "data to memory", mem_wdata, 8'hA0 + i);
      chk("R6", "hold kept", hold, 1);
      chk("R9", "no early tc", tc, 0);
      step();
    end
    #1;
    chk("R6", "hold dropped", hold, 0);
    chk("R9", "tc pulse", tc, 1);
    chk("R6", "no more dack", dack, 0);
    step(); #1;
    chk("R9", "tc one clock", tc, 0);
    rd(2'd1, v); chk("R9", "count zero", v, 0);
    dreq = 1'b0; hlda = 1'b0;
    step();
  endtask

  task automatic t_steal();
    int done = 0, gap = 0, tcs = 0;
    logic prev_byte = 1'b0;
    logic dv;
    logic [RW-1:0] v;
    wr(2'd2, 16'h0007);
    wr(2'd0, 16'h0200);
    wr(2'd1, 16'd2);
    for (int k = 0; k < 16; k++) begin
      dv = (done < 2) && !(done == 1 && gap < 3);
      dreq = dv; hlda = hold; mem_rdata = 8'h50 + 8'(done);
      #1;
      if (prev_byte) chk("R7", "hold low after byte", hold, 0);
      if (done == 1 && !dv) begin
        chk("R7", "no re-request while dreq idle", hold, 0);
        gap++;
      end
      if (tc) tcs++;
      prev_byte = dack;
      if (dack) begin
        chk("R4", "read strobe", {mem_rd, mem_wr}, 2'b10);
        chk("R4", "data to peripheral", io_wdata, 8'h50 + done);
        chk("R5", "addr down", mem_addr, 16'h0200 - done);
        done++;
      end
      step();
    end
    chk("R7", "bytes moved", done, 2);
    chk("R9", "single tc", tcs, 1);
    rd(2'd1, v); chk("R5", "count drained", v, 0);
    dreq = 1'b0; hlda = 1'b0;
    step();
  endtask

  task automatic t_hidden();
    logic [7:0] pat = 8'b0101_1001;
    int done = 0;
    logic tc_exp = 1'b0;
    logic exp;
    wr(2'd2, 16'h0008);
    wr(2'd0, 16'h0300);
    wr(2'd1, 16'd3);
    dreq = 1'b1;
    for (int k = 0; k < 8; k++) begin
      bus_float = pat[k]; #1;
      exp = pat[k] && (done < 3);
      chk("R8", "never hold", hold, 0);
      chk("R8", "dack only when floated", dack, exp);
      chk("R9", "tc timing", tc, tc_exp);
      tc_exp = 1'b0;
      if (exp) begin
        chk("R8", "hidden addr", mem_addr, 16'h0300 + done);
        done++;
        if (done == 3) tc_exp = 1'b1;
      end
      step();
    end
    chk("R8", "bytes moved", done, 3);
    dreq = 1'b0; bus_float = 1'b0;
    step();
  endtask

  task automatic t_withdraw();
    int done = 0, gapc = 0, tcs = 0;
    logic wd;
    logic [RW-1:0] v;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0400);
    wr(2'd1, 16'd3);
    dreq = 1'b1;
    for (int k = 0; k < 16; k++) begin
      wd = (done == 1) && (gapc < 2);
      hlda = hold && !wd; #1;
      if (tc) tcs++;
      if (wd) begin
        chk("R10", "hold kept while grant gone", hold, 1);
        chk("R10", "no byte without grant", dack, 0);
        rd(2'd1, v); chk("R10", "count kept", v, 2);
        gapc++;
      end
      if (dack) begin
        chk("R10", "resumed addr", mem_addr, 16'h0400 + done);
        done++;
      end
      step();
    end
    chk("R10", "bytes moved", done, 3);
    chk("R9", "single tc", tcs, 1);
    dreq = 1'b0; hlda = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_burst();
    t_steal();
    t_hidden();
    t_withdraw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule